// File: doc/BRIEF.md
# Keypad Capture Register

This block converts a bank of synchronous key lines into a compact key code. It keeps the most recent keystroke in a capture register until software polls it through a small memory-mapped read port. The key lines are arranged as a number of groups, each with a fixed number of positions. A priority encoder inside each group finds the lowest active position. A second encoder picks the lowest group that has any active line. The group number and the position are joined to form the key code; with the default sizes this is 3 + 4 = 7 bits.

A keystroke is taken when the key bank goes from fully idle to having at least one active line. The code is written into the capture register and a valid flag is raised. A processor read of the key register clears the flag. The code itself stays in place until the next keystroke replaces it. The block decodes one word of its address window. Every other word in the window reads as zero. Debouncing of the contacts, matrix scanning and interrupt signalling are handled elsewhere.

Top module: `keypadCapture`

## Requirements
- R1: After reset, a read of the key register returns 0: the valid flag is clear and the stored code is 0.
- R2: The key code of line n is n. Code bits [6:4] hold the group index (n / 16) and bits [3:0] hold the position within the group (n % 16). Lines 0 and 127 give codes 0x00 and 0x7F.
- R3: When several lines are active in the cycle of a capture, the lowest-numbered line provides the code.
- R4: A capture happens only at a clock edge where at least one line is active and no line was active at the previous edge. Lines that are held, or added while another line is held, do not capture again.
- R5: The stored code keeps its value from one capture to the next. Reads of the register and idle key lines do not change it.
- R6: Read data bit 7 is the valid flag. A capture sets it, and a read of the key register clears it.
- R7: If a capture and a key-register read fall on the same edge, the read returns the contents from before that edge, and the valid flag stays set with the new code stored.
- R8: A capture that arrives while the valid flag is still set replaces the stored code.
- R9: A read with rdEn high at a clock edge updates rdData at that edge. rdData then holds until the next read. A read of the key register returns {24'b0, valid, code}. The key register is the word whose address bits [11:2] equal 3 (byte offsets 0x00C to 0x00F); address bits [1:0] are ignored.
- R10: A read of any other word in the 12-bit window returns 0 and leaves the valid flag and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyLines | input | 128 | Key lines, already synchronised and debounced; line n = group*16 + position |
| rdEn | input | 1 | Read strobe, sampled at the rising clock edge |
| rdAddr | input | 12 | Byte address within the device window |
| rdData | output | 32 | Registered read data |

## Verification
The bench builds the block with its default sizes: 8 groups of 16 lines, a 12-bit window and the key register at word 3. With these sizes all 128 codes can be reached, including both end codes 0x00 and 0x7F. The random address mix reaches both the decoded word, at every byte offset within it, and words that differ from it only in upper address bits. Random key patterns with zero, one or two active lines, plus held patterns, drive the idle-to-active detection, the lowest-line priority and the overwrite of an unread code in many orders.

// File: rtl/kpCapturePkg.sv
package kpCapturePkg;

  typedef struct packed {
    logic captureEn;  // take the winning code into the capture register
    logic readHit;    // read addressed to the key register
    logic readAny;    // any read this cycle
  } kpStrobes_t;

endpackage

// File: rtl/kpPosEncoder.sv
module kpPosEncoder #(
  parameter int LINES = 16,
  localparam int POS_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] lines,
  output logic             anyLine,
  output logic [POS_W-1:0] pos
);

  always_comb begin
    pos = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (lines[i]) pos = POS_W'(i);
    end
  end

  assign anyLine = |lines;

endmodule

// File: rtl/kpDatapath.sv
module kpDatapath
  import kpCapturePkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int GROUP_W    = $clog2(GROUPS),
  localparam int POS_W      = $clog2(LINES),
  localparam int CODE_W     = GROUP_W + POS_W,
  localparam int LINE_TOTAL = GROUPS * LINES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_TOTAL-1:0] keyLines,
  input  kpStrobes_t            strobes,
  output logic                  anyKey,
  output logic [DATA_W-1:0]     rdData
);

  logic [GROUPS-1:0] groupAny;
  logic [POS_W-1:0]  groupPos [GROUPS];
  logic [GROUP_W-1:0] groupSel;
  logic [CODE_W-1:0]  winCode;
  logic [CODE_W-1:0]  keyCode;
  logic               validBit;
  logic [DATA_W-1:0]  keyWord;

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    kpPosEncoder #(.LINES(LINES)) uPos (
      .lines  (keyLines[g*LINES +: LINES]),
      .anyLine(groupAny[g]),
      .pos    (groupPos[g])
    );
  end

  always_comb begin
    groupSel = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (groupAny[g]) groupSel = GROUP_W'(g);
    end
  end

  assign anyKey  = |groupAny;
  assign winCode = {groupSel, groupPos[groupSel]};
  assign keyWord = {{(DATA_W - CODE_W - 1){1'b0}}, validBit, keyCode};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCode  <= '0;
      validBit <= 1'b0;
    end else if (strobes.captureEn) begin
      keyCode  <= winCode;
      validBit <= 1'b1;
    end else if (strobes.readHit) begin
      validBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.readAny) begin
      rdData <= strobes.readHit ? keyWord : '0;
    end
  end

  // R3: the winning line is active and no lower line is active
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    anyKey |-> (keyLines[winCode] && ((keyLines & ~({LINE_TOTAL{1'b1}} << winCode)) == '0)));

  a_r6_capture_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> validBit);

  a_r6_read_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readHit && !strobes.captureEn) |=> !validBit);

  a_r5_code_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureEn |=> $stable(keyCode));

  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readAny && !strobes.readHit) |=> (rdData == '0));

  a_r10_miss_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.readHit && !strobes.captureEn) |=> $stable(validBit));

  a_r9_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readHit |=> (rdData[DATA_W-1:CODE_W+1] == '0));

  a_r9_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readAny |=> $stable(rdData));

endmodule

// File: rtl/kpControl.sv
module kpControl
  import kpCapturePkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int KEY_WORD = 3,
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyKey,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] rdWord,
  output kpStrobes_t        strobes
);

  localparam logic [WORD_W-1:0] KeyWordAddr = WORD_W'(KEY_WORD);

  logic prevAny;

  always_ff @(posedge clk) begin
    if (!rstN) prevAny <= 1'b0;
    else       prevAny <= anyKey;
  end

  always_comb begin
    strobes.captureEn = anyKey && !prevAny;
    strobes.readAny   = rdEn;
    strobes.readHit   = rdEn && (rdWord == KeyWordAddr);
  end

  // R4: a key bank that stays busy never triggers a second capture
  a_r4_held_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    anyKey |=> !strobes.captureEn);

  a_r4_capture_needs_key: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |-> anyKey);

endmodule

// File: rtl/keypadCapture.sv
module keypadCapture
  import kpCapturePkg::*;
#(
  parameter int GROUPS   = 8,
  parameter int LINES    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int KEY_WORD = 3,
  localparam int LINE_TOTAL = GROUPS * LINES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_TOTAL-1:0] keyLines,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData
);

  kpStrobes_t strobes;
  logic       anyKey;
  logic       unusedByteSel;

  assign unusedByteSel = ^rdAddr[1:0];

  kpControl #(.ADDR_W(ADDR_W), .KEY_WORD(KEY_WORD)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .anyKey (anyKey),
    .rdEn   (rdEn),
    .rdWord (rdAddr[ADDR_W-1:2]),
    .strobes(strobes)
  );

  kpDatapath #(.GROUPS(GROUPS), .LINES(LINES), .DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .keyLines(keyLines),
    .strobes (strobes),
    .anyKey  (anyKey),
    .rdData  (rdData)
  );

endmodule

// File: tb/keypadCapture_test.sv
module keypadCapture_test;

  localparam logic [11:0] KeyAddr  = 12'h00C;
  localparam logic [11:0] MissAddr = 12'h008;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] keyLines = '0;
  logic         rdEn = 1'b0;
  logic [11:0]  rdAddr = '0;
  logic [31:0]  rdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int expCode = 0;
  bit expValid = 0;
  bit prevAny = 0;

  keypadCapture uut (
    .clk(clk), .rstN(rstN), .keyLines(keyLines),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #5 clk = ~clk;

  function automatic int lowestLine(input logic [127:0] k);
    for (int i = 0; i < 128; i++) if (k[i]) return i;
    return -1;
  endfunction

  function automatic logic [127:0] oneLine(input int n);
    logic [127:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  // One clock: drive after the falling edge, check after the rising edge.
  task automatic step(input logic [127:0] k, input bit rd, input logic [11:0] a,
                      input string tag);
    bit any, cap, hit;
    logic [31:0] exp;
    @(negedge clk);
    keyLines = k;
    rdEn = rd;
    rdAddr = a;
    any = |k;
    cap = any && !prevAny;
    hit = rd && (a[11:2] == 10'd3);
    exp = hit ? {24'd0, expValid, 7'(expCode)} : 32'd0;
    @(posedge clk);
    #2;
    if (rd) begin
      total++;
      if (rdData !== exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdData, exp);
      end
    end
    if (cap) begin
      expCode = lowestLine(k);
      expValid = 1;
    end else if (hit) begin
      expValid = 0;
    end
    prevAny = any;
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] k;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    step('0, 1, KeyAddr, "R1 reset state");
    // R2, R6: single press, read sets then clears valid
    step(oneLine(37), 0, '0, "R2");
    step('0, 1, KeyAddr, "R2 line 37 code, R6 valid set");
    step('0, 1, KeyAddr, "R6 valid cleared, R5 code kept");
    // R3 simultaneous press
    step(oneLine(90) | oneLine(17) | oneLine(100), 0, '0, "R3");
    step('0, 1, KeyAddr, "R3 lowest line wins");
    // R4 held key with added line
    step(oneLine(5), 0, '0, "R4");
    step(oneLine(5) | oneLine(3), 0, '0, "R4");
    step(oneLine(3), 1, KeyAddr, "R4 no recapture while held");
    step('0, 0, '0, "R4");
    // R2 boundaries
    step(oneLine(127), 0, '0, "R2");
    step('0, 1, 12'h00F, "R2 max code, R9 byte offset ignored");
    step(oneLine(0), 0, '0, "R2");
    step('0, 1, KeyAddr, "R2 min code");
    // R8 overwrite unread code
    step(oneLine(64), 0, '0, "R8");
    step('0, 0, '0, "R8");
    step(oneLine(66), 0, '0, "R8");
    step('0, 1, 12'h00D, "R8 overwrite");
    // R10 miss reads
    step(oneLine(12), 0, '0, "R10");
    step('0, 1, MissAddr, "R10 miss reads zero");
    step('0, 1, 12'h80C, "R10 upper bit miss");
    step('0, 1, KeyAddr, "R10 valid survived miss");
    // R7 capture and read on same edge
    step(oneLine(50), 1, KeyAddr, "R7 read returns prior contents");
    step('0, 1, KeyAddr, "R7 new code stored with valid");
    step('0, 1, KeyAddr, "R5 code retained after clear");

    for (int it = 0; it < 3000; it++) begin
      case ($urandom % 4)
        0: k = '0;
        1: k = oneLine(int'($urandom % 128));
        2: k = oneLine(int'($urandom % 128)) | oneLine(int'($urandom % 128));
        default: k = keyLines;
      endcase
      if ($urandom % 2 == 0)
        step(k, ($urandom % 3) == 0, {10'd3, 2'($urandom)}, "R9 random key read");
      else
        step(k, ($urandom % 4) == 0, 12'($urandom), "R10 random address read");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule